// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialisation

This block keeps an asynchronous DRAM alive without help from the access path. It also brings the DRAM out of power-up. After reset it stays silent for a start-up pause of at least 200 µs. It then runs a fixed number of CAS-before-RAS wake-up cycles on its own strobes, with no bus arbitration, because no access may happen yet. When the last of these cycles has fully precharged, it raises `ready`, and the access sequencer may start work.

From then on an interval timer adds one owed refresh per slot. The slot length is the refresh window of the selected variant divided by its row count: 4096 rows in 64 ms, or 2048 rows in 32 ms. While any refresh is owed, the scheduler raises `ref_req`. The access sequencer closes its open page and answers with `bus_gnt`. Each refresh cycle starts only on a clock edge where the grant is high. Owed refreshes are then run back to back.

The sequencer may keep the bus for a while, and refreshes build up meanwhile. When the count of owed refreshes reaches a set limit, `force_close` tells the sequencer to give up its page at once. Every wait is derived from nanosecond parameters and the clock period. The scheduler drives its strobes high whenever it is not running a cycle, so they can be merged with the sequencer's strobes.

Top module: `rfs_refresh_sched`

## Requirements
- R1: While `rst` is high, `ras_n` and `cas_n` are 1 and `ready`, `ref_req` and `force_close` are 0.
- R2: After reset is released, both strobes stay high for PAUSE = ceil(STARTUP_NS / clock period) cycles, and `cas_n` first reads 0 in cycle PAUSE+1, counting the first clock edge after reset as cycle 1.
- R3: In every refresh cycle, `cas_n` falls exactly LEAD = ceil(T_CSR_NS / period) cycles before `ras_n` falls. `ras_n` is never low while `cas_n` is high.
- R4: `ras_n` stays low for exactly ACT = max(ceil(T_RAS_NS / period), ceil(T_CHR_NS / period)) cycles, and `cas_n` rises in the same cycle as `ras_n`.
- R5: Once the strobes rise, they both stay high for at least PRE+1 cycles before `cas_n` falls again, where PRE = ceil(T_RP_NS / period).
- R6: The number of wake-up cycles is INIT_CYCLES (8). They run without any grant. `ready` rises in the cycle after the last precharge cycle of the final wake-up cycle, and it stays high until reset.
- R7: Once `ready` is high, one refresh becomes owed every INTERVAL cycles, counted from the cycle in which `ready` rose. INTERVAL = floor(window / rows / period). The 4k variant uses 64 ms and 4096 rows; the 2k variant uses 32 ms and 2048 rows.
- R8: `ref_req` is high exactly when at least one refresh is owed or a refresh cycle is still in progress. It stays low before `ready`.
- R9: After `ready`, a refresh cycle begins (`cas_n` falls) exactly when three conditions held at the preceding edge: no cycle was in progress, a refresh was owed, and `bus_gnt` was high. A grant with nothing owed starts nothing.
- R10: The owed count goes up by one per interval and down by one at the end of each refresh cycle. It saturates at BACKLOG_MAX (4). `force_close` is high exactly when the count equals BACKLOG_MAX.
- R11: While the grant stays high and refreshes remain owed, consecutive refresh cycles are separated by exactly PRE+1 high cycles on `ras_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_gnt | input | 1 | Sequencer has closed its access and hands the strobes over |
| ras_n | output | 1 | Row strobe from the scheduler, active low, high when idle |
| cas_n | output | 1 | Column strobe from the scheduler, active low, high when idle |
| ready | output | 1 | Power-up initialisation finished |
| ref_req | output | 1 | Refresh owed or in progress; asks for the bus |
| force_close | output | 1 | Backlog full; sequencer must close its page now |

## Verification
The hardest state to reach from the ports is a saturated backlog. The grant must be withheld for more intervals than the limit allows, so that owed refreshes pile up to BACKLOG_MAX and extra interval ticks are absorbed. Only then is the grant released, so the whole backlog drains back to back.

The bench reaches this state with a directed phase. It withholds `bus_gnt` for BACKLOG_MAX+2 intervals, then grants and measures the gaps between the drained cycles. After that, random grant patterns drop the grant in the middle of cycles and offer grants when nothing is owed. A bench model of the owed count is checked against `ref_req`, `force_close` and every CAS fall.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_INIT,
        PH_RUN
    } phase_e;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_LEAD,
        EN_ACT,
        EN_PRE
    } eng_e;

    typedef enum logic {
        VARIANT_2K,
        VARIANT_4K
    } variant_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    // Round a time in ns up to whole clocks, never below one clock.
    function automatic int ns_to_cycles(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int refresh_rows(input variant_e v);
        return (v == VARIANT_4K) ? 4096 : 2048;
    endfunction

    function automatic longint refresh_window_ns(input variant_e v);
        return (v == VARIANT_4K) ? longint'(64_000_000) : longint'(32_000_000);
    endfunction

    // Spacing between distributed refreshes, rounded down so the window is met.
    function automatic int interval_cycles(input variant_e v, input int clk_ps);
        longint slot_ps;
        longint c;
        slot_ps = refresh_window_ns(v) * 1000 / refresh_rows(v);
        c = slot_ps / clk_ps;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/rfs_cbr_engine.sv
`timescale 1ns/1ps
module rfs_cbr_engine
    import rfs_pkg::*;
#(
    parameter int LEAD_CYC = 1,
    parameter int ACT_CYC  = 3,
    parameter int PRE_CYC  = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output strobe_t strobe,
    output logic    busy,
    output logic    done
);

    localparam int MAX_CYC = max2(LEAD_CYC, max2(ACT_CYC, PRE_CYC));
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] LEAD_LD = CW'(LEAD_CYC - 1);
    localparam logic [CW-1:0] ACT_LD  = CW'(ACT_CYC - 1);
    localparam logic [CW-1:0] PRE_LD  = CW'(PRE_CYC - 1);

    eng_e          state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= EN_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                EN_IDLE: begin
                    if (start) begin
                        state <= EN_LEAD;
                        cnt   <= LEAD_LD;
                    end
                end
                EN_LEAD: begin
                    if (cnt == '0) begin
                        state <= EN_ACT;
                        cnt   <= ACT_LD;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                EN_ACT: begin
                    if (cnt == '0) begin
                        state <= EN_PRE;
                        cnt   <= PRE_LD;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                EN_PRE: begin
                    if (cnt == '0) begin
                        state <= EN_IDLE;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: state <= EN_IDLE;
            endcase
        end
    end

    always_comb begin
        strobe.cas_n = !((state == EN_LEAD) || (state == EN_ACT));
        strobe.ras_n = !(state == EN_ACT);
        busy         = (state != EN_IDLE);
        done         = (state == EN_PRE) && (cnt == '0);
    end

endmodule

// File: rtl/rfs_interval_timer.sv
`timescale 1ns/1ps
module rfs_interval_timer #(
    parameter int PERIOD_CYC = 781
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);

    localparam int TW = $clog2(PERIOD_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(PERIOD_CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + TW'(1);
        end
    end

    assign tick = en && (cnt == LAST);

endmodule

// File: rtl/rfs_backlog.sv
`timescale 1ns/1ps
module rfs_backlog #(
    parameter int LIMIT = 4,
    parameter int OW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [OW-1:0] owed,
    output logic          full
);

    localparam int SW = OW + 1;

    logic          dec_ok;
    logic [SW-1:0] sum;
    logic [OW-1:0] nxt;

    always_comb begin
        dec_ok = dec && (owed != '0);
        sum    = {1'b0, owed} + SW'(inc) - SW'(dec_ok);
        if (sum > SW'(LIMIT)) begin
            nxt = OW'(LIMIT);
        end else begin
            nxt = sum[OW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else begin
            owed <= nxt;
        end
    end

    assign full = (owed == OW'(LIMIT));

endmodule

// File: rtl/rfs_refresh_sched.sv
`timescale 1ns/1ps
module rfs_refresh_sched
    import rfs_pkg::*;
#(
    parameter int       CLK_PS      = 20000,
    parameter variant_e VARIANT     = VARIANT_4K,
    parameter int       STARTUP_NS  = 200000,
    parameter int       INIT_CYCLES = 8,
    parameter int       BACKLOG_MAX = 4,
    parameter int       T_CSR_NS    = 10,
    parameter int       T_CHR_NS    = 10,
    parameter int       T_RAS_NS    = 60,
    parameter int       T_RP_NS     = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_gnt,
    output logic ras_n,
    output logic cas_n,
    output logic ready,
    output logic ref_req,
    output logic force_close
);

    localparam int PAUSE_CYC    = ns_to_cycles(STARTUP_NS, CLK_PS);
    localparam int LEAD_CYC     = ns_to_cycles(T_CSR_NS, CLK_PS);
    localparam int ACT_CYC      = max2(ns_to_cycles(T_RAS_NS, CLK_PS),
                                       ns_to_cycles(T_CHR_NS, CLK_PS));
    localparam int PRE_CYC      = ns_to_cycles(T_RP_NS, CLK_PS);
    localparam int INTERVAL_CYC = interval_cycles(VARIANT, CLK_PS);
    localparam int PW           = $clog2(PAUSE_CYC + 1);
    localparam int IW           = $clog2(INIT_CYCLES + 1);
    localparam int OW           = $clog2(BACKLOG_MAX + 1);

    phase_e        phase;
    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_cnt;

    strobe_t       strobe;
    logic          eng_busy;
    logic          eng_done;
    logic          eng_start;
    logic          tick;
    logic [OW-1:0] owed;
    logic          owed_full;
    logic          in_run;

    assign in_run = (phase == PH_RUN);

    // Power-up phases: silent pause, wake-up cycles, then normal running.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_PAUSE;
            pause_cnt <= PW'(PAUSE_CYC - 1);
            init_cnt  <= '0;
        end else begin
            case (phase)
                PH_PAUSE: begin
                    if (pause_cnt == '0) begin
                        phase <= PH_INIT;
                    end else begin
                        pause_cnt <= pause_cnt - PW'(1);
                    end
                end
                PH_INIT: begin
                    if (eng_done) begin
                        if (init_cnt == IW'(INIT_CYCLES - 1)) begin
                            phase <= PH_RUN;
                        end else begin
                            init_cnt <= init_cnt + IW'(1);
                        end
                    end
                end
                PH_RUN:  phase <= PH_RUN;
                default: phase <= PH_PAUSE;
            endcase
        end
    end

    always_comb begin
        eng_start = 1'b0;
        if (!eng_busy) begin
            if (phase == PH_INIT) begin
                eng_start = 1'b1;
            end else if (in_run && (owed != '0) && bus_gnt) begin
                eng_start = 1'b1;
            end
        end
    end

    rfs_cbr_engine #(
        .LEAD_CYC (LEAD_CYC),
        .ACT_CYC  (ACT_CYC),
        .PRE_CYC  (PRE_CYC)
    ) u_engine (
        .clk    (clk),
        .rst    (rst),
        .start  (eng_start),
        .strobe (strobe),
        .busy   (eng_busy),
        .done   (eng_done)
    );

    rfs_interval_timer #(
        .PERIOD_CYC (INTERVAL_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (in_run),
        .tick (tick)
    );

    rfs_backlog #(
        .LIMIT (BACKLOG_MAX),
        .OW    (OW)
    ) u_backlog (
        .clk  (clk),
        .rst  (rst),
        .inc  (tick),
        .dec  (eng_done && in_run),
        .owed (owed),
        .full (owed_full)
    );

    assign ras_n       = strobe.ras_n;
    assign cas_n       = strobe.cas_n;
    assign ready       = in_run;
    assign ref_req     = in_run && ((owed != '0) || eng_busy);
    assign force_close = owed_full;

endmodule

// File: rtl/rfs_refresh_chk.sv
`timescale 1ns/1ps
module rfs_refresh_chk (
    input logic clk,
    input logic rst,
    input logic bus_gnt,
    input logic ras_n,
    input logic cas_n,
    input logic ready,
    input logic ref_req,
    input logic force_close
);

    AST_RAS_NEEDS_CAS: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> !cas_n);                                          // R3

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> $past(!cas_n));                             // R3

    AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> $rose(cas_n));                              // R4

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $past(ready) |-> ready);                                     // R6

    AST_QUIET_BEFORE_READY: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (!ref_req && !force_close));                      // R8

    AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (ready && $fell(cas_n)) |-> $past(bus_gnt));                 // R9

    AST_FORCE_IMPLIES_REQ: assert property (@(posedge clk) disable iff (rst)
        force_close |-> ref_req);                                    // R10

endmodule

bind rfs_refresh_sched rfs_refresh_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_gnt     (bus_gnt),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .ready       (ready),
    .ref_req     (ref_req),
    .force_close (force_close)
);

// File: tb/tb_rfs_refresh_sched.sv
`timescale 1ns/1ps
module tb_rfs_refresh_sched;

    localparam int CLK_PS = 20000;
    localparam int BMAX   = 4;

    function automatic int b_ceil(input int ns);
        int c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int b_interval();
        longint v;
        v = longint'(64_000_000) * 1000 / 4096 / CLK_PS;
        return int'(v);
    endfunction

    localparam int PAUSE = b_ceil(200000);
    localparam int LEAD  = b_ceil(10);
    localparam int ACT   = (b_ceil(60) > b_ceil(10)) ? b_ceil(60) : b_ceil(10);
    localparam int PRE   = b_ceil(40);
    localparam int INTV  = b_interval();

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_gnt = 1'b0;
    logic ras_n, cas_n, ready, ref_req, force_close;

    always #10 clk = ~clk;

    rfs_refresh_sched dut (
        .clk         (clk),
        .rst         (rst),
        .bus_gnt     (bus_gnt),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .ready       (ready),
        .ref_req     (ref_req),
        .force_close (force_close)
    );

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor state
    int   samp = 0;
    int   ready_at = 0;
    bit   seen_ready = 1'b0;
    bit   first_cas = 1'b0;
    int   cas_lo_run = 0;
    int   ras_lo_run = 0;
    int   ras_hi_run = 0;
    int   cbr_cnt = 0;
    int   exp_owed = 0;
    int   exp_prev = 0;
    bit   busy_prev = 1'b0;
    bit   cyc_in_run = 1'b0;
    logic ras_p = 1'b1;
    logic cas_p = 1'b1;
    logic req_p = 1'b0;
    bit   phase_a = 1'b0;
    int   last_rise = 0;
    bit   flush = 1'b0;
    int   flush_cnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            chk(ras_n && cas_n && !ready && !ref_req && !force_close, "R1 reset outputs",
                {ras_n, cas_n, ready, ref_req, force_close}, 5'b11000);
            ras_hi_run = 0;
        end else begin
            bit fell_cas, fell_ras, rose_ras, rose_cas, tick, dec, exp_start, busy_now;
            samp++;
            fell_cas = cas_p && !cas_n;
            fell_ras = ras_p && !ras_n;
            rose_ras = !ras_p && ras_n;
            rose_cas = !cas_p && cas_n;

            if (fell_cas && !first_cas) begin
                first_cas = 1'b1;
                chk(samp == PAUSE + 1, "R2 first CAS fall cycle", samp, PAUSE + 1);
            end
            if (fell_ras)
                chk(cas_lo_run == LEAD && !cas_n, "R3 CAS lead before RAS", cas_lo_run, LEAD);
            if (rose_ras)
                chk(ras_lo_run == ACT && rose_cas, "R4 RAS low width / joint rise", ras_lo_run, ACT);
            if (fell_cas && first_cas && cbr_cnt > 0)
                chk(ras_hi_run >= PRE + 1, "R5 precharge before next CAS", ras_hi_run, PRE + 1);

            if (ready && !seen_ready) begin
                seen_ready = 1'b1;
                ready_at   = samp;
                last_rise  = samp;
                exp_owed   = 0;
                exp_prev   = 0;
                busy_prev  = 1'b0;
                chk(cbr_cnt == 8, "R6 wake-up count at ready", cbr_cnt, 8);
                chk(ras_hi_run == PRE, "R6 ready after last precharge", ras_hi_run, PRE);
            end else if (seen_ready) begin
                chk(ready, "R6 ready stays high", ready, 1);
            end else begin
                chk(!ref_req && !force_close, "R8 quiet before ready", ref_req, 0);
            end

            if (seen_ready && samp > ready_at) begin
                tick = ((samp - ready_at) % INTV) == 0;
                dec  = ras_n && (ras_hi_run == PRE) && cyc_in_run;
                exp_owed = exp_owed + (tick ? 1 : 0) - (dec ? 1 : 0);
                if (exp_owed > BMAX) exp_owed = BMAX;
                if (exp_owed < 0) exp_owed = 0;
                exp_start = !busy_prev && (exp_prev > 0) && bus_gnt;
                chk(fell_cas == exp_start, "R9 refresh start condition", fell_cas, exp_start);
                if (dec) cyc_in_run = 1'b0;
                if (fell_cas) cyc_in_run = 1'b1;
                busy_now = !cas_n || !ras_n || (cyc_in_run && ras_n && ras_hi_run < PRE);
                chk(ref_req == (exp_owed != 0 || busy_now), "R8 ref_req level",
                    ref_req, (exp_owed != 0 || busy_now));
                chk(force_close == (exp_owed == BMAX), "R10 force_close level",
                    force_close, (exp_owed == BMAX));
                if (phase_a && ref_req && !req_p) begin
                    chk(samp - last_rise == INTV, "R7 refresh spacing", samp - last_rise, INTV);
                    last_rise = samp;
                end
                if (flush && fell_cas) begin
                    if (flush_cnt > 0)
                        chk(ras_hi_run == PRE + 1, "R11 back-to-back gap", ras_hi_run, PRE + 1);
                    flush_cnt++;
                end
                exp_prev  = exp_owed;
                busy_prev = busy_now;
            end

            cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
            ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
            ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
            if (fell_ras) cbr_cnt++;
            ras_p = ras_n;
            cas_p = cas_n;
            req_p = ref_req;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit acc_open;
        void'($urandom(32'h5eed_1234));
        acc_open = 1'b0;
        repeat (4) @(negedge clk);
        #2 rst = 1'b0;

        while (!seen_ready) @(negedge clk);

        // Phase A: grant always on (also while nothing owed: must start nothing)
        #2 bus_gnt = 1'b1;
        phase_a = 1'b1;
        repeat (5 * INTV + 20) @(negedge clk);
        phase_a = 1'b0;

        // Phase B: hold the bus long enough to saturate the backlog
        #2 bus_gnt = 1'b0;
        repeat ((BMAX + 2) * INTV) @(negedge clk);
        chk(force_close && ref_req, "R10 saturated backlog forces close",
            {force_close, ref_req}, 2'b11);
        #2 bus_gnt = 1'b1;
        flush = 1'b1;
        @(negedge clk);
        while (ref_req) @(negedge clk);
        flush = 1'b0;
        chk(flush_cnt >= BMAX, "R11 full backlog drained", flush_cnt, BMAX);

        // Phase C: random sequencer activity with spurious grants
        for (int i = 0; i < 25 * INTV; i++) begin
            @(negedge clk);
            #2;
            if ($urandom % 16 == 0) acc_open = !acc_open;
            if (force_close && acc_open && ($urandom % 8 == 0)) acc_open = 1'b0;
            bus_gnt = !acc_open && (ref_req || ($urandom % 4 == 0));
        end
        bus_gnt = 1'b1;
        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule